// File: doc/BRIEF.md
# Data Bus Tenure Selector

This block is the bus-master side of a split-transaction bus. It decides which pending data transfer goes next and when the master takes ownership of the shared data bus. Each transaction whose address phase finished cleanly is placed in a short in-order queue, with a read/write flag, a tag and a beat count. The central arbiter drives an active-low data grant. An active-low address-retry input cancels the address phase of the current cycle. An active-low write-only input lets a queued write overtake reads that were pipelined ahead of it.

On a qualified grant the block drives its active-low data-busy output low and reports the tag and direction of the transaction it picked. It holds ownership until the slave has acknowledged the programmed number of beats. It then releases the bus and removes the finished entry from the queue. There is no data-retry path, so once a tenure starts it always runs to completion.

Top module: `data_tenure_sel`

## Requirements
- R1: After reset `dbusy_n` is 1, `q_level` is 0 and `q_full` is 0.
- R2: A grant is qualified only in a cycle where `dgrant_n` is 0, `aretry_n` is 1, `q_level` is non-zero and no tenure is in progress. `dbusy_n` goes to 0 in the cycle after that edge, and `act_tag`/`act_write` then show the chosen entry.
- R3: A `push_valid` in a cycle where `aretry_n` is 0 is not queued.
- R4: With `wr_only_n` = 1 at the granting edge, the oldest queued entry is served, whether it is a read or a write.
- R5: With `wr_only_n` = 0 at the granting edge and at least one write queued, the oldest write is served, even if older reads are queued ahead of it.
- R6: With `wr_only_n` = 0 at the granting edge and no write queued, the oldest read is served.
- R7: A length field value v (`push_len`) means v+1 beats. A beat is one edge with `xfer_ack_n` = 0 while `dbusy_n` is 0, and edges with `xfer_ack_n` = 1 do not count. `dbusy_n` returns to 1 in the cycle after the last beat.
- R8: After a release `dbusy_n` stays 1 for at least one cycle. If `dgrant_n` is held at 0 and entries remain, `dbusy_n` goes low again after exactly one high cycle.
- R9: A finished entry leaves the queue. The remaining entries keep their relative age order.
- R10: `q_full` is 1 when `DEPTH` entries are queued, and a push in that state is dropped. A push on the same edge as a completion is still queued.
- R11: While a tenure is in progress, `dgrant_n` and `wr_only_n` have no effect: `act_tag`/`act_write` stay stable. Pushes are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | An address phase finished this cycle |
| push_write | input | 1 | 1 = write transaction, 0 = read |
| push_tag | input | TAG_W | Transaction identifier |
| push_len | input | LEN_W | Beat count minus one |
| aretry_n | input | 1 | Active-low address retry for the current cycle |
| dgrant_n | input | 1 | Active-low data bus grant |
| wr_only_n | input | 1 | Active-low: serve the oldest write first |
| xfer_ack_n | input | 1 | Active-low beat acknowledge |
| dbusy_n | output | 1 | Active-low data bus ownership |
| act_tag | output | TAG_W | Tag of the transaction in tenure |
| act_write | output | 1 | Direction of the transaction in tenure |
| q_level | output | CNT_W | Number of queued entries |
| q_full | output | 1 | Queue holds DEPTH entries |

## Verification
Two things can land on the same clock edge: the final beat acknowledge, which removes the finished entry, and a fresh push, which appends one. The bench provokes this by asserting `push_valid` in the same cycle as the last `xfer_ack_n`. It then judges the result from the level, which must equal the old level, and from the order of the two grants that follow, which must serve the survivor first and then the new entry. A second overlap is the release edge with the grant still held low. That case is judged by requiring exactly one high cycle of `dbusy_n` before the next tenure starts.

// File: rtl/dts_pkg.sv
package dts_pkg;
  parameter int unsigned TAG_W = 4;
  parameter int unsigned LEN_W = 2;

  typedef struct packed {
    logic             wr;
    logic [LEN_W-1:0] len;
    logic [TAG_W-1:0] tag;
  } dts_entry_t;

  typedef enum logic {
    TEN_IDLE = 1'b0,
    TEN_XFER = 1'b1
  } ten_state_t;
endpackage

// File: rtl/dts_rst_sync.sv
module dts_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dts_queue.sv
module dts_queue
  import dts_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_en,
  input  dts_entry_t             push_ent,
  input  logic                   pop_en,
  input  logic [IDX_W-1:0]       pop_idx,
  output dts_entry_t [DEPTH-1:0] ents,
  output logic [DEPTH-1:0]       wr_mask,
  output logic [CNT_W-1:0]       level,
  output logic                   full
);
  dts_entry_t [DEPTH-1:0] mem_q, mem_d;
  logic [CNT_W-1:0]       lvl_q, lvl_d, lvl_after;
  logic                   mem_en;

  // next-state: close the gap left by a pop, then append at the tail
  always_comb begin
    lvl_after = lvl_q - (pop_en ? CNT_W'(1) : CNT_W'(0));
    mem_d     = mem_q;
    for (int i = 0; i < int'(DEPTH) - 1; i++) begin
      if (pop_en && (IDX_W'(i) >= pop_idx)) mem_d[i] = mem_q[i+1];
    end
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (push_en && (lvl_after == CNT_W'(i))) mem_d[i] = push_ent;
    end
    lvl_d  = lvl_after + (push_en ? CNT_W'(1) : CNT_W'(0));
    mem_en = push_en | pop_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (mem_en) lvl_q <= lvl_d;
  end

  always_ff @(posedge clk) begin
    if (mem_en) mem_q <= mem_d;
  end

  always_comb begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      wr_mask[i] = mem_q[i].wr && (CNT_W'(i) < lvl_q);
    end
  end

  assign ents  = mem_q;
  assign level = lvl_q;
  assign full  = (lvl_q == CNT_W'(DEPTH));
endmodule

// File: rtl/dts_pick.sv
module dts_pick #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] wr_mask,
  input  logic [CNT_W-1:0] level,
  input  logic             wr_only,
  output logic [IDX_W-1:0] pick_idx,
  output logic             pick_ok
);
  logic [IDX_W-1:0] wr_idx;
  logic             wr_hit;

  // lowest index wins: scan from the youngest slot down to the oldest
  always_comb begin
    wr_idx = '0;
    wr_hit = 1'b0;
    for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
      if (wr_mask[i]) begin
        wr_idx = IDX_W'(i);
        wr_hit = 1'b1;
      end
    end
  end

  assign pick_ok  = (level != '0);
  assign pick_idx = (wr_only && wr_hit) ? wr_idx : '0;
endmodule

// File: rtl/dts_tenure.sv
module dts_tenure
  import dts_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_req,
  input  logic [IDX_W-1:0] pick_idx,
  input  dts_entry_t       pick_ent,
  input  logic             beat_ack,
  output logic             busy,
  output dts_entry_t       cur_ent,
  output logic             pop_en,
  output logic [IDX_W-1:0] pop_idx
);
  ten_state_t       st_q, st_d;
  logic [LEN_W-1:0] beat_q, beat_d;
  logic [IDX_W-1:0] idx_q;
  dts_entry_t       ent_q;
  logic             load_en, last_beat;

  assign last_beat = beat_ack && (beat_q == ent_q.len);

  always_comb begin
    st_d    = st_q;
    beat_d  = beat_q;
    load_en = 1'b0;
    unique case (st_q)
      TEN_IDLE: begin
        if (grant_req) begin
          st_d    = TEN_XFER;
          beat_d  = '0;
          load_en = 1'b1;
        end
      end
      TEN_XFER: begin
        if (last_beat)     st_d   = TEN_IDLE;
        else if (beat_ack) beat_d = beat_q + LEN_W'(1);
      end
      default: st_d = TEN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TEN_IDLE;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      idx_q <= pick_idx;
      ent_q <= pick_ent;
    end
  end

  assign busy    = (st_q == TEN_XFER);
  assign cur_ent = ent_q;
  assign pop_en  = busy && last_beat;
  assign pop_idx = idx_q;
endmodule

// File: rtl/data_tenure_sel.sv
module data_tenure_sel
  import dts_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic             push_write,
  input  logic [TAG_W-1:0] push_tag,
  input  logic [LEN_W-1:0] push_len,
  input  logic             aretry_n,
  input  logic             dgrant_n,
  input  logic             wr_only_n,
  input  logic             xfer_ack_n,
  output logic             dbusy_n,
  output logic [TAG_W-1:0] act_tag,
  output logic             act_write,
  output logic [CNT_W-1:0] q_level,
  output logic             q_full
);
  logic                   rst_n_int;
  logic                   push_en, pop_en, grant_req, pick_ok, busy;
  logic [IDX_W-1:0]       pick_idx, pop_idx;
  logic [DEPTH-1:0]       wr_mask;
  dts_entry_t [DEPTH-1:0] ents;
  dts_entry_t             push_ent, cur_ent;

  dts_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign push_ent  = '{wr: push_write, len: push_len, tag: push_tag};
  assign push_en   = push_valid && aretry_n && !q_full;
  assign grant_req = !dgrant_n && aretry_n && pick_ok && !busy;

  dts_queue #(.DEPTH(DEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .push_en  (push_en),
    .push_ent (push_ent),
    .pop_en   (pop_en),
    .pop_idx  (pop_idx),
    .ents     (ents),
    .wr_mask  (wr_mask),
    .level    (q_level),
    .full     (q_full)
  );

  dts_pick #(.DEPTH(DEPTH)) u_pick (
    .wr_mask  (wr_mask),
    .level    (q_level),
    .wr_only  (!wr_only_n),
    .pick_idx (pick_idx),
    .pick_ok  (pick_ok)
  );

  dts_tenure #(.DEPTH(DEPTH)) u_tenure (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .grant_req (grant_req),
    .pick_idx  (pick_idx),
    .pick_ent  (ents[pick_idx]),
    .beat_ack  (!xfer_ack_n),
    .busy      (busy),
    .cur_ent   (cur_ent),
    .pop_en    (pop_en),
    .pop_idx   (pop_idx)
  );

  assign dbusy_n   = !busy;
  assign act_tag   = cur_ent.tag;
  assign act_write = cur_ent.wr;
endmodule

// File: rtl/dts_checker.sv
module dts_checker
  import dts_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             aretry_n,
  input logic             dgrant_n,
  input logic             xfer_ack_n,
  input logic             dbusy_n,
  input logic [TAG_W-1:0] act_tag,
  input logic             act_write,
  input logic [CNT_W-1:0] q_level,
  input logic             q_full
);
  assert_grant_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dbusy_n) |-> $past(!dgrant_n && aretry_n && (q_level != '0)));

  assert_retry_no_enqueue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !aretry_n && dbusy_n) |=> (q_level == $past(q_level)));

  assert_release_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbusy_n) |-> $past(!xfer_ack_n));

  assert_pop_on_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbusy_n) |-> (int'(q_level) ==
      int'($past(q_level)) - 1 + int'($past(push_valid && aretry_n && !q_full))));

  assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_level) <= int'(DEPTH));

  assert_tenure_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbusy_n && $past(!dbusy_n)) |-> ($stable(act_tag) && $stable(act_write)));
endmodule

bind data_tenure_sel dts_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_valid (push_valid),
  .aretry_n   (aretry_n),
  .dgrant_n   (dgrant_n),
  .xfer_ack_n (xfer_ack_n),
  .dbusy_n    (dbusy_n),
  .act_tag    (act_tag),
  .act_write  (act_write),
  .q_level    (q_level),
  .q_full     (q_full)
);

// File: tb/tb_data_tenure_sel.sv
`timescale 1ns/1ps
module tb_data_tenure_sel;
  localparam int DEPTH = 4;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n, push_valid, push_write, aretry_n, dgrant_n, wr_only_n, xfer_ack_n;
  logic [3:0] push_tag;
  logic [1:0] push_len;
  logic dbusy_n, act_write, q_full;
  logic [3:0] act_tag;
  logic [CNT_W-1:0] q_level;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  data_tenure_sel #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_write(push_write),
    .push_tag(push_tag), .push_len(push_len), .aretry_n(aretry_n),
    .dgrant_n(dgrant_n), .wr_only_n(wr_only_n), .xfer_ack_n(xfer_ack_n),
    .dbusy_n(dbusy_n), .act_tag(act_tag), .act_write(act_write),
    .q_level(q_level), .q_full(q_full)
  );

  // {entries, write mask (bit i = entry i), write-only, expected tag, length field}
  localparam logic [13:0] VEC [8] = '{
    {3'd3, 4'b0000, 1'b0, 4'd1, 2'd0},
    {3'd3, 4'b0010, 1'b1, 4'd2, 2'd1},
    {3'd4, 4'b1000, 1'b1, 4'd4, 2'd2},
    {3'd2, 4'b0000, 1'b1, 4'd1, 2'd3},
    {3'd4, 4'b0110, 1'b0, 4'd1, 2'd1},
    {3'd4, 4'b1111, 1'b1, 4'd1, 2'd0},
    {3'd1, 4'b0001, 1'b0, 4'd1, 2'd2},
    {3'd4, 4'b1100, 1'b1, 4'd3, 2'd3}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; push_valid = 1'b0; push_write = 1'b0; push_tag = '0; push_len = '0;
    aretry_n = 1'b1; dgrant_n = 1'b1; wr_only_n = 1'b1; xfer_ack_n = 1'b1;
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic push_one(input logic w, input int tag, input int len);
    push_valid = 1'b1; push_write = w; push_tag = 4'(tag); push_len = 2'(len);
    tick();
    push_valid = 1'b0;
  endtask

  task automatic grant(input logic wo);
    dgrant_n = 1'b0; wr_only_n = ~wo;
    tick();
    dgrant_n = 1'b1; wr_only_n = 1'b1;
  endtask

  task automatic finish_beats(input int len);
    xfer_ack_n = 1'b0;
    for (int k = 0; k <= len; k++) begin
      tick();
      check("R7 beat count", int'(dbusy_n), (k < len) ? 0 : 1);
    end
    xfer_ack_n = 1'b1;
  endtask

  task automatic serve(input logic wo, input int exp_tag, input string req, input int len);
    grant(wo);
    check("R2 busy on grant", int'(dbusy_n), 0);
    check(req, int'(act_tag), exp_tag);
    finish_beats(len);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 dbusy_n", int'(dbusy_n), 1);
    check("R1 q_level", int'(q_level), 0);
    check("R1 q_full", int'(q_full), 0);

    // table walk: R4 / R5 / R6 selection, R7 length, R9 removal
    for (int v = 0; v < 8; v++) begin
      logic [2:0] n;
      logic [3:0] wm, et;
      logic       wo;
      logic [1:0] ln;
      string      rq;
      {n, wm, wo, et, ln} = VEC[v];
      do_reset();
      for (int i = 0; i < int'(n); i++) push_one(wm[i], i + 1, int'(ln));
      if (!wo)            rq = "R4 oldest served";
      else if (wm != '0)  rq = "R5 oldest write served";
      else                rq = "R6 read served without write";
      serve(wo, int'(et), rq, int'(ln));
      check("R9 level after completion", int'(q_level), int'(n) - 1);
      if (wm[0] == 1'b0 || !wo) check(rq, int'(act_write), int'(wm[int'(et) - 1]));
    end

    // R2: grant with empty queue is not taken
    do_reset();
    dgrant_n = 1'b0; tick(); dgrant_n = 1'b1;
    check("R2 empty queue no tenure", int'(dbusy_n), 1);

    // R3: retried address phase is not queued
    aretry_n = 1'b0; push_one(1'b1, 5, 0); aretry_n = 1'b1;
    check("R3 retried push dropped", int'(q_level), 0);

    // R2: retry in the grant cycle blocks qualification
    push_one(1'b0, 6, 0);
    dgrant_n = 1'b0; aretry_n = 1'b0; tick(); dgrant_n = 1'b1; aretry_n = 1'b1;
    check("R2 retry blocks grant", int'(dbusy_n), 1);
    serve(1'b0, 6, "R2 grant after retry clears", 0);

    // R7 + R11: ack gaps and grant activity during a tenure
    do_reset();
    push_one(1'b0, 1, 1);
    grant(1'b0);
    check("R11 first tag", int'(act_tag), 1);
    dgrant_n = 1'b0; wr_only_n = 1'b0;
    push_one(1'b1, 9, 0);
    tick(); tick();
    dgrant_n = 1'b1; wr_only_n = 1'b1;
    check("R7 ack high holds bus", int'(dbusy_n), 0);
    check("R11 tag stable", int'(act_tag), 1);
    check("R11 push during tenure", int'(q_level), 2);
    finish_beats(1);
    serve(1'b0, 9, "R11 queued write served next", 0);

    // R8: grant held low across a release
    do_reset();
    push_one(1'b0, 1, 0);
    push_one(1'b0, 2, 0);
    dgrant_n = 1'b0;
    tick();
    check("R8 first tenure", int'(act_tag), 1);
    xfer_ack_n = 1'b0; tick(); xfer_ack_n = 1'b1;
    check("R8 released", int'(dbusy_n), 1);
    tick();
    check("R8 one-cycle gap", int'(dbusy_n), 0);
    check("R8 second tag", int'(act_tag), 2);
    dgrant_n = 1'b1;
    finish_beats(0);

    // R10: full queue, extra push dropped
    do_reset();
    for (int i = 0; i < DEPTH; i++) push_one(1'b0, i + 1, 0);
    check("R10 full flag", int'(q_full), 1);
    push_one(1'b1, 7, 0);
    check("R10 push when full dropped", int'(q_level), DEPTH);
    for (int i = 0; i < DEPTH; i++) serve(1'b1, i + 1, "R10 no extra write entered", 0);
    check("R10 drained", int'(q_level), 0);

    // R9: order kept after removal from the middle
    do_reset();
    push_one(1'b0, 1, 0); push_one(1'b1, 2, 0);
    push_one(1'b0, 3, 0); push_one(1'b1, 4, 0);
    serve(1'b1, 2, "R5 write overtakes read", 0);
    serve(1'b0, 1, "R9 order after middle pop", 0);
    serve(1'b1, 4, "R9 next write", 0);
    serve(1'b0, 3, "R9 last entry", 0);

    // R10: push on the completing edge is kept
    do_reset();
    push_one(1'b0, 1, 0); push_one(1'b0, 2, 0);
    grant(1'b0);
    xfer_ack_n = 1'b0;
    push_one(1'b1, 3, 0);
    xfer_ack_n = 1'b1;
    check("R10 push with completion", int'(q_level), 2);
    serve(1'b0, 2, "R9 survivor first", 0);
    serve(1'b0, 3, "R10 new entry after", 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule